// File: doc/BRIEF.md
# Control Register File with Write Side Effects

This block keeps the system control registers of a processor core: five control words, the extended-feature word, the code-segment and stack-segment attribute words, eight segment bases with their effective copies, six debug registers and a time-stamp counter. Software reaches all of them through one indexed write port and one indexed read port. The read port is combinational and reflects the state registered at the most recent clock edge.

Some writes affect more than the target register. Toggling paging while long mode is enabled turns long mode on or off. Changes to paging or to page-size and global-page features send a one-cycle flush-all pulse to the translation buffers. Any write to the page-table base sends a flush-non-global pulse. Toggling the code segment's 64-bit attribute zeroes or restores the effective bases of the four legacy data and code segments. Writes to the debug registers are masked, and two debug indices are aliases of two others.

The time-stamp counter is kept as an offset against a free-running cycle count, so a read always shows an advancing value. A mode-update strobe tells the downstream mode decoder to re-evaluate after any write that can change the operating mode.

Top module: `ctlreg_file`

## Requirements
- R1: After reset every register reads zero, except index 30 (debug status), which reads 0xFFFF0FF0, and index 31 (debug control), which reads 0x00000400; all three pulse outputs are low.
- R2: A write to index 0 (CR0) stores the written value with bit 4 forced to 1. A write to index 1, 2, 3 or 4 (CR2, CR3, CR4, CR8) stores the value unchanged.
- R3: If a CR0 write changes bit 31 (paging) while bit 8 of index 5 (extended-feature word) is 1, bit 10 of index 5 becomes the new bit 31. Otherwise bit 10 keeps its value. A write to index 5 stores every bit except bit 10, which keeps its previous value.
- R4: `tlb_flush_all` is high for exactly the one cycle after a write that either changes CR0 bit 31 or changes CR4 bit 4, 5 or 7. No other write raises it.
- R5: `tlb_flush_nonglobal` is high for exactly the one cycle after any write to index 2 (CR3). No other write raises it.
- R6: When a write to index 6 (code-segment attributes) changes bit 0 (64-bit attribute), the effective bases at indices 16 to 19 (ES, CS, SS, DS) change. They become zero if the new bit is 1. If the new bit is 0, each takes its stored base from indices 8 to 11.
- R7: A write to a stored base at index 8 to 11 always updates that base. It also copies the value into the matching effective base (index + 8), but only when 64-bit mode is off, where 64-bit mode means index 5 bit 10 and index 6 bit 0 are both 1.
- R8: A write to a stored base at index 12 to 15 (FS, GS, TR, IDTR) always updates both the base and its effective base (index + 8). Writes to indices 16 to 23 are ignored.
- R9: Index 32 is the time-stamp counter. Writing V and reading it after k more clock edges (counting the write edge) returns V + k. Without a write, its value rises by one per clock.
- R10: A write to index 30, or to its alias index 28, changes only bits 0 to 3 and 13 to 15 of index 30. Reading index 28 returns index 30.
- R11: A write to index 31, or to its alias index 29, changes only bits 0 to 7, 13 and 16 to 31 of index 31. Reading index 29 returns index 31. Indices 24 to 27 store the written value unchanged.
- R12: `mode_update` is high for exactly the one cycle after a write to index 0, 6 or 7. No other write raises it.
- R13: A read of any index above 32 returns zero. A write to such an index changes no register and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_idx | input | IDX_W | Register index for the write |
| wr_data | input | XLEN | Write value |
| rd_idx | input | IDX_W | Register index for the read |
| rd_data | output | XLEN | Combinational read value |
| tlb_flush_all | output | 1 | One-cycle flush-all request, broadcast to the instruction and data translation buffers |
| tlb_flush_nonglobal | output | 1 | One-cycle flush-non-global request, broadcast to both translation buffers |
| mode_update | output | 1 | One-cycle strobe telling the mode decoder to re-evaluate |

## Verification
The properties assume that index, data and write strobe are at known levels whenever the strobe is high. They also assume that the strobe and the index are settled before the rising edge, so each write is sampled exactly once. The bench changes inputs only on the falling clock edge and holds the strobe for a single cycle per write. Its random indices cover both implemented and unimplemented indices, so ignored writes sit in the same stream as effective ones. Random data reaches every control and attribute bit, so paging toggles with long mode both enabled and disabled, and 64-bit attribute flips, arise without special handling.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
    // register index map
    localparam int IDX_CR0       = 0;
    localparam int IDX_CR2       = 1;
    localparam int IDX_CR3       = 2;
    localparam int IDX_CR4       = 3;
    localparam int IDX_CR8       = 4;
    localparam int IDX_EXTF      = 5;
    localparam int IDX_CSATTR    = 6;
    localparam int IDX_SSATTR    = 7;
    localparam int IDX_BASE0     = 8;
    localparam int IDX_EFF0      = 16;
    localparam int IDX_DBG0      = 24;
    localparam int IDX_DSTAT_AL  = 28;
    localparam int IDX_DCTL_AL   = 29;
    localparam int IDX_DSTAT     = 30;
    localparam int IDX_DCTL      = 31;
    localparam int IDX_TSTAMP    = 32;

    localparam int NSEG          = 8;
    localparam int NFLAT         = 4;
    localparam int NDBG          = 4;

    // bit positions
    localparam int B_CR0_ET      = 4;
    localparam int B_CR0_PG      = 31;
    localparam int B_CR4_PSE     = 4;
    localparam int B_CR4_PAE     = 5;
    localparam int B_CR4_PGE     = 7;
    localparam int B_EXT_LME     = 8;
    localparam int B_EXT_LMA     = 10;
    localparam int B_ATTR_L64    = 0;

    localparam logic [31:0] DSTAT_RST  = 32'hFFFF_0FF0;
    localparam logic [31:0] DCTL_RST   = 32'h0000_0400;
    localparam logic [31:0] DSTAT_WMSK = 32'h0000_E00F;
    localparam logic [31:0] DCTL_WMSK  = 32'hFFFF_20FF;
endpackage

// File: rtl/ctlreg_cycle_ctr.sv
module ctlreg_cycle_ctr #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ctlreg_masked_merge.sv
module ctlreg_masked_merge #(
    parameter int         W    = 64,
    parameter logic [31:0] MASK = 32'h0
) (
    input  logic [W-1:0] old_val,
    input  logic [W-1:0] new_val,
    output logic [W-1:0] merged
);
    localparam logic [W-1:0] WMASK = W'(MASK);

    always_comb begin
        merged = (old_val & ~WMASK) | (new_val & WMASK);
    end
endmodule

// File: rtl/ctlreg_seg_eff.sv
module ctlreg_seg_eff #(
    parameter int XLEN         = 64,
    parameter bit FLAT_IN_LONG = 1'b1
) (
    input  logic [XLEN-1:0] eff_q,
    input  logic [XLEN-1:0] base_q,
    input  logic [XLEN-1:0] wr_data,
    input  logic            base_wr,
    input  logic            lm_toggle,
    input  logic            lm_new,
    input  logic            in_64,
    output logic [XLEN-1:0] eff_d
);
    generate
        if (FLAT_IN_LONG) begin : g_flat
            always_comb begin
                eff_d = eff_q;
                if (lm_toggle) begin
                    eff_d = lm_new ? '0 : base_q;
                end else if (base_wr && !in_64) begin
                    eff_d = wr_data;
                end
            end
        end else begin : g_fixed
            logic unused_in;
            assign unused_in = lm_toggle ^ lm_new ^ in_64 ^ (^base_q);
            always_comb begin
                eff_d = base_wr ? wr_data : eff_q;
            end
        end
    endgenerate
endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
    import ctlreg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data,
    output logic             tlb_flush_all,
    output logic             tlb_flush_nonglobal,
    output logic             mode_update
);
    typedef struct packed {
        logic [XLEN-1:0]            cr0;
        logic [XLEN-1:0]            cr2;
        logic [XLEN-1:0]            cr3;
        logic [XLEN-1:0]            cr4;
        logic [XLEN-1:0]            cr8;
        logic [XLEN-1:0]            extf;
        logic [XLEN-1:0]            cs_attr;
        logic [XLEN-1:0]            ss_attr;
        logic [NSEG-1:0][XLEN-1:0]  seg_base;
        logic [NSEG-1:0][XLEN-1:0]  seg_eff;
        logic [NDBG-1:0][XLEN-1:0]  dbg;
        logic [XLEN-1:0]            dstat;
        logic [XLEN-1:0]            dctl;
        logic [XLEN-1:0]            ts_off;
        logic                       flush_all;
        logic                       flush_ng;
        logic                       mode_upd;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [XLEN-1:0]            cyc;
    logic [XLEN-1:0]            dstat_merged;
    logic [XLEN-1:0]            dctl_merged;
    logic [NSEG-1:0][XLEN-1:0]  seg_eff_nx;
    logic [NSEG-1:0]            base_hit;
    logic                       in_64;
    logic                       lm_toggle;

    // signals exposed to the bound checker
    logic [XLEN-1:0]            cr0_q;
    logic [XLEN-1:0]            extf_q;
    logic [XLEN-1:0]            dstat_q;
    logic [XLEN-1:0]            fs_base_q;
    logic [XLEN-1:0]            fs_eff_q;

    ctlreg_cycle_ctr #(.W(XLEN)) u_cyc (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cyc)
    );

    ctlreg_masked_merge #(.W(XLEN), .MASK(DSTAT_WMSK)) u_dstat_merge (
        .old_val (st_q.dstat),
        .new_val (wr_data),
        .merged  (dstat_merged)
    );

    ctlreg_masked_merge #(.W(XLEN), .MASK(DCTL_WMSK)) u_dctl_merge (
        .old_val (st_q.dctl),
        .new_val (wr_data),
        .merged  (dctl_merged)
    );

    assign in_64     = st_q.extf[B_EXT_LMA] & st_q.cs_attr[B_ATTR_L64];
    assign lm_toggle = wr_en && (wr_idx == IDX_W'(IDX_CSATTR))
                       && (st_q.cs_attr[B_ATTR_L64] != wr_data[B_ATTR_L64]);

    genvar gs;
    generate
        for (gs = 0; gs < NSEG; gs++) begin : g_seg
            assign base_hit[gs] = wr_en && (wr_idx == IDX_W'(IDX_BASE0 + gs));
            ctlreg_seg_eff #(
                .XLEN         (XLEN),
                .FLAT_IN_LONG (gs < NFLAT)
            ) u_seg_eff (
                .eff_q     (st_q.seg_eff[gs]),
                .base_q    (st_q.seg_base[gs]),
                .wr_data   (wr_data),
                .base_wr   (base_hit[gs]),
                .lm_toggle (lm_toggle),
                .lm_new    (wr_data[B_ATTR_L64]),
                .in_64     (in_64),
                .eff_d     (seg_eff_nx[gs])
            );
        end
    endgenerate

    // next-state computation
    always_comb begin
        logic pg_flip;
        logic cr4_flip;
        st_d           = st_q;
        st_d.flush_all = 1'b0;
        st_d.flush_ng  = 1'b0;
        st_d.mode_upd  = 1'b0;
        st_d.seg_eff   = seg_eff_nx;
        pg_flip  = st_q.cr0[B_CR0_PG] ^ wr_data[B_CR0_PG];
        cr4_flip = (st_q.cr4[B_CR4_PSE] ^ wr_data[B_CR4_PSE])
                 | (st_q.cr4[B_CR4_PAE] ^ wr_data[B_CR4_PAE])
                 | (st_q.cr4[B_CR4_PGE] ^ wr_data[B_CR4_PGE]);
        if (wr_en) begin
            case (wr_idx)
                IDX_W'(IDX_CR0): begin
                    st_d.cr0           = wr_data;
                    st_d.cr0[B_CR0_ET] = 1'b1;
                    st_d.mode_upd      = 1'b1;
                    if (pg_flip) begin
                        st_d.flush_all = 1'b1;
                        if (st_q.extf[B_EXT_LME]) begin
                            st_d.extf[B_EXT_LMA] = wr_data[B_CR0_PG];
                        end
                    end
                end
                IDX_W'(IDX_CR2): st_d.cr2 = wr_data;
                IDX_W'(IDX_CR3): begin
                    st_d.cr3      = wr_data;
                    st_d.flush_ng = 1'b1;
                end
                IDX_W'(IDX_CR4): begin
                    st_d.cr4       = wr_data;
                    st_d.flush_all = cr4_flip;
                end
                IDX_W'(IDX_CR8): st_d.cr8 = wr_data;
                IDX_W'(IDX_EXTF): begin
                    st_d.extf            = wr_data;
                    st_d.extf[B_EXT_LMA] = st_q.extf[B_EXT_LMA];
                end
                IDX_W'(IDX_CSATTR): begin
                    st_d.cs_attr  = wr_data;
                    st_d.mode_upd = 1'b1;
                end
                IDX_W'(IDX_SSATTR): begin
                    st_d.ss_attr  = wr_data;
                    st_d.mode_upd = 1'b1;
                end
                IDX_W'(IDX_DSTAT_AL),
                IDX_W'(IDX_DSTAT):  st_d.dstat  = dstat_merged;
                IDX_W'(IDX_DCTL_AL),
                IDX_W'(IDX_DCTL):   st_d.dctl   = dctl_merged;
                IDX_W'(IDX_TSTAMP): st_d.ts_off = wr_data - cyc;
                default: ;
            endcase
            for (int s = 0; s < NSEG; s++) begin
                if (base_hit[s]) st_d.seg_base[s] = wr_data;
            end
            for (int k = 0; k < NDBG; k++) begin
                if (wr_idx == IDX_W'(IDX_DBG0 + k)) st_d.dbg[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.dstat <= XLEN'(DSTAT_RST);
            st_q.dctl  <= XLEN'(DCTL_RST);
        end else begin
            st_q <= st_d;
        end
    end

    // read port
    always_comb begin
        rd_data = '0;
        case (rd_idx)
            IDX_W'(IDX_CR0):     rd_data = st_q.cr0;
            IDX_W'(IDX_CR2):     rd_data = st_q.cr2;
            IDX_W'(IDX_CR3):     rd_data = st_q.cr3;
            IDX_W'(IDX_CR4):     rd_data = st_q.cr4;
            IDX_W'(IDX_CR8):     rd_data = st_q.cr8;
            IDX_W'(IDX_EXTF):    rd_data = st_q.extf;
            IDX_W'(IDX_CSATTR):  rd_data = st_q.cs_attr;
            IDX_W'(IDX_SSATTR):  rd_data = st_q.ss_attr;
            IDX_W'(IDX_DSTAT_AL),
            IDX_W'(IDX_DSTAT):   rd_data = st_q.dstat;
            IDX_W'(IDX_DCTL_AL),
            IDX_W'(IDX_DCTL):    rd_data = st_q.dctl;
            IDX_W'(IDX_TSTAMP):  rd_data = st_q.ts_off + cyc;
            default:             rd_data = '0;
        endcase
        for (int s = 0; s < NSEG; s++) begin
            if (rd_idx == IDX_W'(IDX_BASE0 + s)) rd_data = st_q.seg_base[s];
            if (rd_idx == IDX_W'(IDX_EFF0 + s))  rd_data = st_q.seg_eff[s];
        end
        for (int k = 0; k < NDBG; k++) begin
            if (rd_idx == IDX_W'(IDX_DBG0 + k)) rd_data = st_q.dbg[k];
        end
    end

    assign tlb_flush_all       = st_q.flush_all;
    assign tlb_flush_nonglobal = st_q.flush_ng;
    assign mode_update         = st_q.mode_upd;

    assign cr0_q     = st_q.cr0;
    assign extf_q    = st_q.extf;
    assign dstat_q   = st_q.dstat;
    assign fs_base_q = st_q.seg_base[NFLAT];
    assign fs_eff_q  = st_q.seg_eff[NFLAT];
endmodule

// File: rtl/ctlreg_file_chk.sv
module ctlreg_file_chk
    import ctlreg_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic [XLEN-1:0]  wr_data,
    input logic             tlb_flush_all,
    input logic             tlb_flush_nonglobal,
    input logic             mode_update,
    input logic [XLEN-1:0]  cr0_q,
    input logic [XLEN-1:0]  extf_q,
    input logic [XLEN-1:0]  dstat_q,
    input logic [XLEN-1:0]  fs_base_q,
    input logic [XLEN-1:0]  fs_eff_q
);
    localparam logic [XLEN-1:0] KEEP_MSK = ~XLEN'(DSTAT_WMSK);

    AST_CR0_ET_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_CR0)) |=> cr0_q[B_CR0_ET]); // R2

    AST_LMA_TRACKS_PG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_CR0) && extf_q[B_EXT_LME]
         && (cr0_q[B_CR0_PG] != wr_data[B_CR0_PG]))
        |=> (extf_q[B_EXT_LMA] == $past(wr_data[B_CR0_PG]))); // R3

    AST_FLUSH_ALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_all |-> $past(wr_en && (wr_idx == IDX_W'(IDX_CR0)
                                          || wr_idx == IDX_W'(IDX_CR4)))); // R4

    AST_CR3_FLUSH_NG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(IDX_CR3)) |=> tlb_flush_nonglobal); // R5

    AST_FLUSH_NG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_flush_nonglobal |-> $past(wr_en && wr_idx == IDX_W'(IDX_CR3))); // R5

    AST_FS_EFF_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        fs_eff_q == fs_base_q); // R8

    AST_DSTAT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dstat_q & KEEP_MSK) == ($past(dstat_q) & KEEP_MSK)); // R10

    AST_MODE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_update |-> $past(wr_en && (wr_idx == IDX_W'(IDX_CR0)
                                        || wr_idx == IDX_W'(IDX_CSATTR)
                                        || wr_idx == IDX_W'(IDX_SSATTR)))); // R12
endmodule

bind ctlreg_file ctlreg_file_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
    .clk                 (clk),
    .rst_n               (rst_n),
    .wr_en               (wr_en),
    .wr_idx              (wr_idx),
    .wr_data             (wr_data),
    .tlb_flush_all       (tlb_flush_all),
    .tlb_flush_nonglobal (tlb_flush_nonglobal),
    .mode_update         (mode_update),
    .cr0_q               (cr0_q),
    .extf_q              (extf_q),
    .dstat_q             (dstat_q),
    .fs_base_q           (fs_base_q),
    .fs_eff_q            (fs_eff_q)
);

// File: tb/ctlreg_file_bench.sv
`timescale 1ns/1ps
module ctlreg_file_bench;
    localparam int XLEN  = 64;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_idx = '0;
    logic [XLEN-1:0]  wr_data = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic [XLEN-1:0]  rd_data;
    logic             tlb_flush_all;
    logic             tlb_flush_nonglobal;
    logic             mode_update;

    int checks = 0;
    int errors = 0;
    logic [63:0] m [0:63];
    logic [63:0] bcyc;

    ctlreg_file #(.XLEN(XLEN), .IDX_W(IDX_W)) u_ctlreg_file (
        .clk                 (clk),
        .rst_n               (rst_n),
        .wr_en               (wr_en),
        .wr_idx              (wr_idx),
        .wr_data             (wr_data),
        .rd_idx              (rd_idx),
        .rd_data             (rd_data),
        .tlb_flush_all       (tlb_flush_all),
        .tlb_flush_nonglobal (tlb_flush_nonglobal),
        .mode_update         (mode_update)
    );

    always #10 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) bcyc <= '0;
        else        bcyc <= bcyc + 64'd1;
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_for(int idx);
        if (idx == 5) return "R3";
        if (idx < 8) return "R2";
        if (idx < 12) return "R7";
        if (idx < 24) return "R8";
        if (idx < 30) return "R11";
        if (idx == 30) return "R10";
        if (idx == 31) return "R11";
        if (idx == 32) return "R9";
        return "R13";
    endfunction

    function automatic logic [63:0] model_rd(int idx);
        if (idx == 28) return m[30];
        if (idx == 29) return m[31];
        if (idx == 32) return m[32] + bcyc;
        if (idx > 32) return 64'd0;
        return m[idx];
    endfunction

    // reference model of a write, evaluated on the pre-write state
    task automatic model_wr(int idx, logic [63:0] v, output bit fa, output bit ng, output bit mu);
        bit tog;
        fa = 0; ng = 0; mu = 0;
        case (idx)
            0: begin
                tog = m[0][31] ^ v[31];
                if (tog && m[5][8]) m[5][10] = v[31];
                fa = tog; mu = 1;
                m[0] = v | 64'h10;
            end
            1, 4: m[idx] = v;
            2: begin m[2] = v; ng = 1; end
            3: begin
                fa = (m[3][4] ^ v[4]) | (m[3][5] ^ v[5]) | (m[3][7] ^ v[7]);
                m[3] = v;
            end
            5: m[5] = (v & ~64'h400) | (m[5] & 64'h400);
            6: begin
                if (m[6][0] ^ v[0])
                    for (int s = 0; s < 4; s++) m[16+s] = v[0] ? 64'd0 : m[8+s];
                m[6] = v; mu = 1;
            end
            7: begin m[7] = v; mu = 1; end
            8, 9, 10, 11: begin
                if (!(m[5][10] && m[6][0])) m[idx+8] = v;
                m[idx] = v;
            end
            12, 13, 14, 15: begin m[idx] = v; m[idx+8] = v; end
            24, 25, 26, 27: m[idx] = v;
            28, 30: m[30] = (m[30] & ~64'hE00F) | (v & 64'hE00F);
            29, 31: m[31] = (m[31] & ~64'hFFFF20FF) | (v & 64'hFFFF20FF);
            32: m[32] = v - bcyc;
            default: ;
        endcase
    endtask

    task automatic do_wr(int idx, logic [63:0] v);
        bit fa, ng, mu;
        model_wr(idx, v, fa, ng, mu);
        wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_data = v;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R4",  $sformatf("flush_all after idx %0d", idx), 64'(tlb_flush_all), 64'(fa));
        chk("R5",  $sformatf("flush_ng after idx %0d", idx), 64'(tlb_flush_nonglobal), 64'(ng));
        chk("R12", $sformatf("mode_update after idx %0d", idx), 64'(mode_update), 64'(mu));
    endtask

    task automatic chk_rd(int idx, string req);
        rd_idx = IDX_W'(idx);
        #1;
        chk(req, $sformatf("read idx %0d", idx), rd_data, model_rd(idx));
    endtask

    task automatic chk_lit(int idx, logic [63:0] exp, string req);
        rd_idx = IDX_W'(idx);
        #1;
        chk(req, $sformatf("read idx %0d", idx), rd_data, exp);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] t0;
        void'($urandom(32'd5150));
        for (int i = 0; i < 64; i++) m[i] = 64'd0;
        m[30] = 64'hFFFF_0FF0;
        m[31] = 64'h0000_0400;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1", "flush_all at reset", 64'(tlb_flush_all), 64'd0);
        chk("R1", "flush_ng at reset", 64'(tlb_flush_nonglobal), 64'd0);
        chk("R1", "mode_update at reset", 64'(mode_update), 64'd0);
        chk_lit(0, 64'd0, "R1");
        chk_lit(30, 64'hFFFF_0FF0, "R1");
        chk_lit(31, 64'h0000_0400, "R1");
        for (int i = 0; i < 32; i++) chk_rd(i, "R1");

        // R2 CR0 ET forced
        do_wr(0, 64'd0);
        chk_lit(0, 64'h10, "R2");
        // R3 extended-feature write keeps LMA
        do_wr(5, 64'h500);
        chk_lit(5, 64'h100, "R3");
        // R3/R4 paging on with long mode enabled
        do_wr(0, 64'h8000_0001);
        chk_lit(5, 64'h500, "R3");
        chk_lit(0, 64'h8000_0011, "R2");
        // R4 CR4 toggles
        do_wr(3, 64'h20);
        do_wr(3, 64'h21);
        do_wr(3, 64'h01);
        // R5
        do_wr(2, 64'h1234_5000);
        // R7 base write outside 64-bit mode
        do_wr(8, 64'hAAAA);
        chk_lit(16, 64'hAAAA, "R7");
        // R6 enter 64-bit attribute
        do_wr(6, 64'h1);
        chk_lit(16, 64'd0, "R6");
        // R7 base write in 64-bit mode leaves effective zero
        do_wr(8, 64'hBBBB);
        chk_lit(16, 64'd0, "R7");
        chk_lit(8, 64'hBBBB, "R7");
        // R8 upper base always tracked
        do_wr(12, 64'hCCCC);
        chk_lit(20, 64'hCCCC, "R8");
        do_wr(20, 64'h1);
        chk_lit(20, 64'hCCCC, "R8");
        // R6 leave 64-bit attribute restores
        do_wr(6, 64'h0);
        chk_lit(16, 64'hBBBB, "R6");
        // R3 paging off turns LMA off
        do_wr(0, 64'h1);
        chk_lit(5, 64'h100, "R3");
        // R9 time stamp
        do_wr(32, 64'h1000);
        chk_lit(32, 64'h1001, "R9");
        repeat (5) @(negedge clk);
        chk_lit(32, 64'h1006, "R9");
        rd_idx = 6'd32; #1; t0 = rd_data;
        repeat (3) @(negedge clk);
        chk("R9", "free running step", rd_data - t0, 64'd3);
        // R10/R11 aliases and masks
        do_wr(28, '1);
        chk_lit(30, 64'h0000_0000_FFFF_EFFF, "R10");
        chk_lit(28, 64'h0000_0000_FFFF_EFFF, "R10");
        do_wr(29, '1);
        chk_lit(31, 64'h0000_0000_FFFF_24FF, "R11");
        chk_lit(29, 64'h0000_0000_FFFF_24FF, "R11");
        do_wr(31, 64'd0);
        chk_lit(31, 64'h400, "R11");
        // R13 unimplemented index
        do_wr(45, '1);
        chk_lit(45, 64'd0, "R13");
        for (int i = 0; i < 33; i++) chk_rd(i, "R13");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int idx;
            int ri;
            logic [63:0] v;
            idx = int'($urandom % 40);
            v = {$urandom, $urandom};
            if ($urandom % 4 == 0) v = v & 64'h0000_0000_8000_01B1;
            do_wr(idx, v);
            ri = int'($urandom % 40);
            chk_rd(ri, req_for(ri));
            chk_rd(idx, req_for(idx));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule